// File: doc/BRIEF.md
# Multi-Event Trigger Buffer Controller

This block decides, module-wide, which triggers are accepted and when the module goes dead. It counts accepted triggers, gives each one an event number inside the current buffer cycle, and lets several events build up in the on-board sample buffers. When a fixed number of events is stored (five by default), it raises busy and a trigger veto, and it requests an interrupt from the readout CPU. The module then stays dead until the CPU has drained the data and issues a software reset.

The raw trigger input is asynchronous. It passes through a synchronizer and a rising-edge detector, so a pulse of any length counts as one trigger. Each accepted trigger also pushes its running trigger number into a small trigger FIFO. The CPU can read that FIFO one entry at a time or clear it in a single command. The running trigger number is visible at all times on a status port.

Top module: `evbuf_ctrl`

## Requirements
- R1: After `rst`, `event_num` is 0, `busy`, `trig_veto` and `irq` are low, `trig_count` is 0, and `tfifo_empty` is high.
- R2: A rising edge on `trig_in` that reaches the controller while the veto is low is accepted. Three clock edges after `trig_in` is sampled high, `event_num` and `trig_count` have each gone up by one.
- R3: While `event_num` is below the limit (5), `busy`, `trig_veto` and `irq` stay low.
- R4: On the edge that accepts the fifth event, `event_num` becomes 5 and `busy`, `trig_veto` and `irq` all go high together.
- R5: A trigger that arrives while the veto is high is dropped. `event_num`, `trig_count` and the FIFO contents do not change.
- R6: `busy`, `trig_veto` and `irq` stay high until `sw_reset`. One cycle after `sw_reset`, all three are low and `event_num` is 0. `trig_count` is kept.
- R7: If `sw_reset` falls in the same cycle as an accepted trigger edge, the reset wins and the trigger is dropped.
- R8: A `trig_in` pulse held high for many cycles counts as exactly one trigger.
- R9: Each accepted trigger writes its new `trig_count` value into the trigger FIFO. A one-cycle `tfifo_rd` pulse places the oldest entry on `tfifo_dout` one cycle later.
- R10: When the FIFO is full (8 entries), further writes are dropped and `tfifo_full` is high. A read from an empty FIFO leaves `tfifo_dout` unchanged and `tfifo_empty` high.
- R11: A one-cycle `tfifo_clr` empties the FIFO by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger input |
| sw_reset | input | 1 | CPU reset after readout: clears busy, veto, irq and event number |
| tfifo_rd | input | 1 | Pop one trigger FIFO entry |
| tfifo_clr | input | 1 | Empty the trigger FIFO |
| event_num | output | 3 | Event number in the current buffer cycle (0 means none yet) |
| trig_count | output | 12 | Running number of accepted triggers |
| busy | output | 1 | Buffers hold the full event count |
| trig_veto | output | 1 | Triggers are being refused |
| irq | output | 1 | Readout request to the CPU |
| tfifo_dout | output | 12 | Trigger FIFO read data |
| tfifo_empty | output | 1 | Trigger FIFO holds no entry |
| tfifo_full | output | 1 | Trigger FIFO holds the maximum number of entries |

## Verification
Trigger results arrive three edges after `trig_in` is first sampled high: two synchronizer stages, then the registered count. The bench therefore drives at a falling edge and samples at the third falling edge after that. After each pulse it idles three cycles so the edge detector can re-arm. `sw_reset`, `tfifo_clr` and `tfifo_rd` act on the next rising edge, so their results are sampled one falling edge later. For the reset collision, `sw_reset` is timed to land on the accepting edge.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  typedef enum logic {
    BUF_OPEN = 1'b0,
    BUF_FULL = 1'b1
  } buf_state_e;
endpackage

// File: rtl/evbuf_trig_sync.sv
module evbuf_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sr;
  logic         prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[TOP-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sr[TOP];
  end

  assign rise = sr[TOP] & ~prev;
endmodule

// File: rtl/evbuf_evt_ctl.sv
module evbuf_evt_ctl
  import evbuf_pkg::*;
#(
  parameter int MAX_EVENTS = 5,
  parameter int CNT_W      = 12,
  localparam int EVW       = $clog2(MAX_EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             sw_reset,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_data,
  output logic [EVW-1:0]   event_num,
  output logic [CNT_W-1:0] trig_count,
  output logic             busy,
  output logic             trig_veto,
  output logic             irq
);
  localparam logic [EVW-1:0] LAST_EV = EVW'(MAX_EVENTS);

  buf_state_e state;
  logic       accept;

  assign accept  = rise && (state == BUF_OPEN) && !sw_reset;
  assign wr_en   = accept;
  assign wr_data = trig_count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= BUF_OPEN;
      event_num  <= '0;
      trig_count <= '0;
      busy       <= 1'b0;
      trig_veto  <= 1'b0;
      irq        <= 1'b0;
    end else if (sw_reset) begin
      state      <= BUF_OPEN;
      event_num  <= '0;
      busy       <= 1'b0;
      trig_veto  <= 1'b0;
      irq        <= 1'b0;
    end else if (accept) begin
      trig_count <= trig_count + 1'b1;
      event_num  <= event_num + 1'b1;
      if (event_num == LAST_EV - 1'b1) begin
        state     <= BUF_FULL;
        busy      <= 1'b1;
        trig_veto <= 1'b1;
        irq       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/evbuf_trig_fifo.sv
module evbuf_trig_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign do_wr = wr && !full && !clr;
  assign do_rd = rd && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (do_rd) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10: begin
          cnt   <= cnt + 1'b1;
          empty <= 1'b0;
          full  <= (cnt == CW'(DEPTH - 1));
        end
        2'b01: begin
          cnt   <= cnt - 1'b1;
          full  <= 1'b0;
          empty <= (cnt == CW'(1));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl #(
  parameter int MAX_EVENTS  = 5,
  parameter int CNT_W       = 12,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int EVW        = $clog2(MAX_EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             sw_reset,
  input  logic             tfifo_rd,
  input  logic             tfifo_clr,
  output logic [EVW-1:0]   event_num,
  output logic [CNT_W-1:0] trig_count,
  output logic             busy,
  output logic             trig_veto,
  output logic             irq,
  output logic [CNT_W-1:0] tfifo_dout,
  output logic             tfifo_empty,
  output logic             tfifo_full
);
  logic             rise;
  logic             wr_en;
  logic [CNT_W-1:0] wr_data;

  evbuf_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(trig_in), .rise(rise)
  );

  evbuf_evt_ctl #(.MAX_EVENTS(MAX_EVENTS), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .rise(rise), .sw_reset(sw_reset),
    .wr_en(wr_en), .wr_data(wr_data), .event_num(event_num),
    .trig_count(trig_count), .busy(busy), .trig_veto(trig_veto), .irq(irq)
  );

  evbuf_trig_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(tfifo_clr), .wr(wr_en), .wdata(wr_data),
    .rd(tfifo_rd), .rdata(tfifo_dout), .empty(tfifo_empty), .full(tfifo_full)
  );
endmodule

// File: rtl/evbuf_ctrl_chk.sv
module evbuf_ctrl_chk #(
  parameter int MAX_EVENTS = 5,
  parameter int CNT_W      = 12,
  parameter int EVW        = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_reset,
  input logic [EVW-1:0]   event_num,
  input logic [CNT_W-1:0] trig_count,
  input logic             busy,
  input logic             trig_veto,
  input logic             irq,
  input logic             tfifo_empty,
  input logic             tfifo_full
);
  a_r3_quiet_below_limit: assert property (@(posedge clk) disable iff (rst)
    (event_num < EVW'(MAX_EVENTS)) |-> (!busy && !trig_veto && !irq));

  a_r4_full_flags_together: assert property (@(posedge clk) disable iff (rst)
    (event_num == EVW'(MAX_EVENTS)) |-> (busy && trig_veto && irq));

  a_r5_no_count_when_vetoed: assert property (@(posedge clk) disable iff (rst)
    trig_veto |=> $stable(trig_count));

  a_r6_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !sw_reset) |=> irq);

  a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (!busy && !irq && event_num == '0));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tfifo_full && tfifo_empty));
endmodule

bind evbuf_ctrl evbuf_ctrl_chk #(
  .MAX_EVENTS(MAX_EVENTS), .CNT_W(CNT_W), .EVW(EVW)
) u_chk (
  .clk(clk), .rst(rst), .sw_reset(sw_reset), .event_num(event_num),
  .trig_count(trig_count), .busy(busy), .trig_veto(trig_veto), .irq(irq),
  .tfifo_empty(tfifo_empty), .tfifo_full(tfifo_full)
);

// File: tb/test_evbuf_ctrl.sv
module test_evbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_in = 1'b0, sw_reset = 1'b0, tfifo_rd = 1'b0, tfifo_clr = 1'b0;
  logic [2:0]  event_num;
  logic [11:0] trig_count, tfifo_dout;
  logic        busy, trig_veto, irq, tfifo_empty, tfifo_full;
  int          checks = 0, failures = 0;
  bit          done = 0;
  int          exp_cnt = 0;

  always #10 clk = ~clk;

  evbuf_ctrl i_evbuf_ctrl (
    .clk(clk), .rst(rst), .trig_in(trig_in), .sw_reset(sw_reset),
    .tfifo_rd(tfifo_rd), .tfifo_clr(tfifo_clr), .event_num(event_num),
    .trig_count(trig_count), .busy(busy), .trig_veto(trig_veto), .irq(irq),
    .tfifo_dout(tfifo_dout), .tfifo_empty(tfifo_empty), .tfifo_full(tfifo_full)
  );

  // vector: {op(1=trigger,0=sw_reset), event_num, busy/veto, irq}
  localparam logic [5:0] VEC [12] = '{
    {1'b1, 3'd1, 1'b0, 1'b0}, {1'b1, 3'd2, 1'b0, 1'b0},
    {1'b1, 3'd3, 1'b0, 1'b0}, {1'b1, 3'd4, 1'b0, 1'b0},
    {1'b1, 3'd5, 1'b1, 1'b1}, {1'b1, 3'd5, 1'b1, 1'b1},
    {1'b0, 3'd0, 1'b0, 1'b0}, {1'b1, 3'd1, 1'b0, 1'b0},
    {1'b1, 3'd2, 1'b0, 1'b0}, {1'b1, 3'd3, 1'b0, 1'b0},
    {1'b1, 3'd4, 1'b0, 1'b0}, {1'b1, 3'd5, 1'b1, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig(int hold);
    @(negedge clk) trig_in = 1'b1;
    repeat (hold) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_swrst;
    @(negedge clk) sw_reset = 1'b1;
    @(negedge clk) sw_reset = 1'b0;
  endtask

  task automatic do_read;
    @(negedge clk) tfifo_rd = 1'b1;
    @(negedge clk) tfifo_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 event_num", event_num, 0);
    chk("R1 busy", busy, 0);
    chk("R1 veto", trig_veto, 0);
    chk("R1 irq", irq, 0);
    chk("R1 trig_count", trig_count, 0);
    chk("R1 empty", tfifo_empty, 1);

    // R2 R3 R4 R5 R6: table walk
    foreach (VEC[i]) begin
      if (VEC[i][5]) begin
        pulse_trig(3);
        if (!busy || VEC[i][4:2] != 3'd5 || i == 4 || i == 11) ;
      end else begin
        do_swrst();
      end
      if (VEC[i][5] && !(i == 5)) exp_cnt++;
      chk("R2/R4 event_num", event_num, VEC[i][4:2]);
      chk("R3/R4 busy", busy, VEC[i][1]);
      chk("R3/R4 veto", trig_veto, VEC[i][1]);
      chk("R4/R6 irq", irq, VEC[i][0]);
      chk("R2/R5 trig_count", trig_count, exp_cnt);
      if (VEC[i][5]) idle(3);
    end

    // R6: irq held while waiting, then cleared by sw_reset; count kept
    idle(10);
    chk("R6 irq held", irq, 1);
    do_swrst();
    chk("R6 irq cleared", irq, 0);
    chk("R6 busy cleared", busy, 0);
    chk("R6 event_num", event_num, 0);
    chk("R6 trig_count kept", trig_count, 10);

    // R10: FIFO took only 8 of 10 writes
    chk("R10 full", tfifo_full, 1);
    for (int k = 1; k <= 8; k++) begin
      do_read();
      chk("R9 fifo order", tfifo_dout, k);
    end
    chk("R10 empty after drain", tfifo_empty, 1);
    do_read();
    chk("R10 empty read keeps dout", tfifo_dout, 8);
    chk("R10 still empty", tfifo_empty, 1);

    // R8: long pulse counts once
    pulse_trig(12);
    idle(3);
    chk("R8 event_num", event_num, 1);
    chk("R8 trig_count", trig_count, 11);
    chk("R9 write on accept", tfifo_empty, 0);

    // R11: clear
    @(negedge clk) tfifo_clr = 1'b1;
    @(negedge clk) tfifo_clr = 1'b0;
    chk("R11 empty after clr", tfifo_empty, 1);

    // R7: sw_reset on the accepting edge
    @(negedge clk) trig_in = 1'b1;
    idle(2);
    sw_reset = 1'b1;
    @(negedge clk) sw_reset = 1'b0;
    trig_in = 1'b0;
    chk("R7 event_num", event_num, 0);
    chk("R7 trig_count", trig_count, 11);
    chk("R7 fifo empty", tfifo_empty, 1);
    idle(3);

    // R9: next accepted trigger number lands in FIFO
    pulse_trig(3);
    idle(3);
    chk("R2 event_num", event_num, 1);
    do_read();
    chk("R9 fifo value", tfifo_dout, 12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule